// File: doc/BRIEF.md
# Sequential Shift-Subtract Unsigned Divider

This block divides one unsigned integer by another over several clock cycles, producing one quotient bit per cycle. A single double-width shifting register holds the partial remainder in its upper part and collects quotient bits in its lower part, so the quotient needs no register of its own. The only arithmetic is one adder/subtractor that acts on the upper part. A pulse on `start` while the divider is idle captures the two operands. `busy` stays high while the iterations and the final remainder correction run. A one-cycle `done` pulse then marks the point where `quotient` and `remainder` become valid. Both outputs hold their values until the next division completes.

A compile-time parameter selects one of two algorithms. The restoring variant keeps the old partial remainder whenever a trial subtraction goes negative. The non-restoring variant keeps the negative value and adds the divisor on the next step instead, which takes the restore mux out of the iteration path; a last fix-up then adds the divisor once if the final partial remainder is negative. A zero divisor does not start the iterations. It completes at once with a divide-by-zero flag set.

Top module: `seq_divider`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are 0.
- R2: If `start` is sampled high while `busy` is low and `divisor` is non-zero, `busy` is high for exactly WIDTH+1 cycles starting in the next cycle. `done` is high for exactly one cycle, which is the first cycle after `busy` falls.
- R3: With NONRESTORING=0, the `quotient` presented with `done` equals floor(dividend / divisor) for the captured unsigned operands.
- R4: With NONRESTORING=0, the `remainder` presented with `done` equals dividend mod divisor, and it is always less than the divisor.
- R5: With NONRESTORING=1, `quotient` and `remainder` presented with `done` equal floor(dividend / divisor) and dividend mod divisor, including the cases where the last partial remainder is negative.
- R6: If `start` is sampled high while idle and `divisor` is 0, `done` and `div_by_zero` are high in the next cycle, `busy` stays low, `quotient` is all ones and `remainder` equals the dividend. Any completion with a non-zero divisor clears `div_by_zero`.
- R7: A `start` pulse while `busy` is high has no effect. The running division finishes at its original time with the result for the operands captured first.
- R8: In every cycle where `done` is low, `quotient`, `remainder` and `div_by_zero` keep the values they had in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division; accepted only while idle |
| dividend | input | WIDTH | Unsigned dividend, sampled with an accepted start |
| divisor | input | WIDTH | Unsigned divisor, sampled with an accepted start |
| quotient | output | WIDTH | Quotient of the last completed division |
| remainder | output | WIDTH | Remainder of the last completed division |
| busy | output | 1 | High while iterations or the correction step run |
| done | output | 1 | One-cycle pulse when new results are presented |
| div_by_zero | output | 1 | Set when the last completed division had a zero divisor |

## Verification
The bench builds two copies at WIDTH=4, one with each algorithm, and drives both with the same stimulus. At this width every one of the 256 dividend/divisor pairs can be run and compared against the `/` and `%` operators. This covers the zero divisor, a divisor of 1, dividends below the divisor, all-ones operands, and every sign pattern the non-restoring partial remainder can reach in its last step. The four-cycle iteration count also makes it cheap to check the exact busy length, the single done pulse, the held outputs and a start that arrives mid-run.

// File: rtl/div_pkg.sv
package div_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ITER = 2'd1,
      ST_FIX  = 2'd2
   } div_state_e;
endpackage

// File: rtl/div_step.sv
// One iteration of the divider: trial subtract (or add) on the partial remainder.
module div_step #(
   parameter int WIDTH   = 32,
   parameter bit NONREST = 1'b0
) (
   input  logic [WIDTH+1:0] part_i,
   input  logic [WIDTH-1:0] dvsr_i,
   output logic [WIDTH+1:0] next_o,
   output logic             qbit_o
);
   localparam int PW = WIDTH + 2;

   logic [PW-1:0] dvsr_ext;
   assign dvsr_ext = {2'b00, dvsr_i};

   generate
      if (NONREST) begin : g_nonrest
         // sign of the current partial remainder picks add or subtract
         logic [PW-1:0] sum;
         always_comb begin
            if (part_i[PW-1]) sum = part_i + dvsr_ext;
            else              sum = part_i - dvsr_ext;
         end
         assign next_o = sum;
         assign qbit_o = ~sum[PW-1];
      end else begin : g_rest
         // keep the old value when the trial subtraction underflows
         logic [PW-1:0] diff;
         assign diff   = part_i - dvsr_ext;
         assign qbit_o = ~diff[PW-1];
         assign next_o = diff[PW-1] ? part_i : diff;
      end
   endgenerate
endmodule

// File: rtl/div_fix.sv
// Final correction: undo the extra left shift and, for non-restoring, fix the sign.
module div_fix #(
   parameter int WIDTH   = 32,
   parameter bit NONREST = 1'b0
) (
   input  logic [WIDTH+1:0] part_i,
   input  logic [WIDTH-1:0] dvsr_i,
   output logic [WIDTH-1:0] rem_o
);
   localparam int PW = WIDTH + 2;

   logic [PW-1:0] half;
   logic [PW-1:0] fixed;
   assign half = {part_i[PW-1], part_i[PW-1:1]};

   generate
      if (NONREST) begin : g_nonrest
         always_comb begin
            if (half[PW-1]) fixed = half + {2'b00, dvsr_i};
            else            fixed = half;
         end
      end else begin : g_rest
         assign fixed = half;
      end
   endgenerate

   assign rem_o = fixed[WIDTH-1:0];
endmodule

// File: rtl/div_ctrl.sv
// Sequencer: idle, WIDTH iterations, one correction cycle.
module div_ctrl
   import div_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic zero_div_i,
   output logic load_o,
   output logic zero_o,
   output logic step_o,
   output logic fix_o,
   output logic busy_o
);
   localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   div_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic          accept;

   assign accept = start_i && (state_q == ST_IDLE);
   assign load_o = accept && !zero_div_i;
   assign zero_o = accept && zero_div_i;
   assign step_o = (state_q == ST_ITER);
   assign fix_o  = (state_q == ST_FIX);
   assign busy_o = (state_q != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (load_o) state_q <= ST_ITER;
            end
            ST_ITER: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST) state_q <= ST_FIX;
            end
            ST_FIX:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/seq_divider.sv
// Multi-cycle unsigned divider with a combined remainder/quotient shift register.
module seq_divider #(
   parameter int WIDTH        = 32,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder,
   output logic             busy,
   output logic             done,
   output logic             div_by_zero
);
   localparam int PW = WIDTH + 2;   // upper part carries sign and overflow bit

   generate
      if (WIDTH < 2) begin : g_width_check
         $error("seq_divider: WIDTH must be at least 2");
      end
   endgenerate

   logic             load, zero, step, fix;
   logic [PW-1:0]    hi_q;
   logic [WIDTH-1:0] lo_q;
   logic [WIDTH-1:0] dvsr_q;
   logic [PW-1:0]    hi_next;
   logic             qbit;
   logic [WIDTH-1:0] rem_fixed;

   div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .zero_div_i (divisor == '0),
      .load_o     (load),
      .zero_o     (zero),
      .step_o     (step),
      .fix_o      (fix),
      .busy_o     (busy)
   );

   div_step #(.WIDTH(WIDTH), .NONREST(NONRESTORING)) u_step (
      .part_i (hi_q),
      .dvsr_i (dvsr_q),
      .next_o (hi_next),
      .qbit_o (qbit)
   );

   div_fix #(.WIDTH(WIDTH), .NONREST(NONRESTORING)) u_fix (
      .part_i (hi_q),
      .dvsr_i (dvsr_q),
      .rem_o  (rem_fixed)
   );

   // shifting datapath
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         dvsr_q <= '0;
      end else if (load) begin
         // load dividend in the low part and shift the whole register left once
         hi_q   <= {{(PW-1){1'b0}}, dividend[WIDTH-1]};
         lo_q   <= {dividend[WIDTH-2:0], 1'b0};
         dvsr_q <= divisor;
      end else if (step) begin
         hi_q <= {hi_next[PW-2:0], lo_q[WIDTH-1]};
         lo_q <= {lo_q[WIDTH-2:0], qbit};
      end
   end

   // result registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quotient    <= '0;
         remainder   <= '0;
         div_by_zero <= 1'b0;
         done        <= 1'b0;
      end else begin
         done <= fix | zero;
         if (fix) begin
            quotient    <= lo_q;
            remainder   <= rem_fixed;
            div_by_zero <= 1'b0;
         end else if (zero) begin
            quotient    <= '1;
            remainder   <= dividend;
            div_by_zero <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/div_checker.sv
module div_checker #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [WIDTH-1:0] dividend,
   input logic [WIDTH-1:0] divisor,
   input logic [WIDTH-1:0] quotient,
   input logic [WIDTH-1:0] remainder,
   input logic             busy,
   input logic             done,
   input logic             div_by_zero
);
   localparam int DW = 2 * WIDTH;
   localparam int CW = $clog2(WIDTH + 3);

   logic [WIDTH-1:0] a_q, b_q;
   logic [CW-1:0]    busy_cnt;
   logic [DW-1:0]    recon;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q      <= '0;
         b_q      <= '0;
         busy_cnt <= '0;
      end else begin
         if (start && !busy) begin
            a_q <= dividend;
            b_q <= divisor;
         end
         if (busy) busy_cnt <= busy_cnt + 1'b1;
         else      busy_cnt <= '0;
      end
   end

   assign recon = ({{WIDTH{1'b0}}, quotient} * {{WIDTH{1'b0}}, b_q}) + {{WIDTH{1'b0}}, remainder};

   // R1
   p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !busy && !done && !div_by_zero);

   // R2
   p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && divisor != '0) |=> busy);
   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_by_zero) |-> (busy_cnt == CW'(WIDTH + 1)) && !busy);

   // R3, R4, R5: quotient * divisor + remainder reproduces the dividend
   p_identity_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_by_zero) |-> (recon == {{WIDTH{1'b0}}, a_q}) && (remainder < b_q));

   // R6
   p_zero_divisor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && divisor == '0) |=> done && div_by_zero && !busy && (&quotient));

   // R8
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(quotient) && $stable(remainder) && $stable(div_by_zero));
endmodule

bind seq_divider div_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/seq_divider_test.sv
`timescale 1ns/1ps
module seq_divider_test;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] dividend = '0;
   logic [W-1:0] divisor = '0;

   logic [W-1:0] q_r, r_r, q_n, r_n;
   logic         busy_r, done_r, dbz_r, busy_n, done_n, dbz_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   seq_divider #(.WIDTH(W), .NONRESTORING(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
      .quotient(q_r), .remainder(r_r), .busy(busy_r), .done(done_r), .div_by_zero(dbz_r));

   seq_divider #(.WIDTH(W), .NONRESTORING(1'b1)) uut_nr (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
      .quotient(q_n), .remainder(r_n), .busy(busy_n), .done(done_n), .div_by_zero(dbz_n));

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_results(input int a, input int b);
      check("R3", "restoring quotient", int'(q_r), a / b);
      check("R4", "restoring remainder", int'(r_r), a % b);
      check("R5", "non-restoring quotient", int'(q_n), a / b);
      check("R5", "non-restoring remainder", int'(r_n), a % b);
      check("R6", "flag clear", int'(dbz_r) + int'(dbz_n), 0);
   endtask

   // One division; when ia >= 0 a second start with (ia, ib) is issued mid-run.
   task automatic run_one(input int a, input int b, input int ia, input int ib);
      logic [W-1:0] hq, hr;
      @(negedge clk);
      start = 1'b1; dividend = W'(a); divisor = W'(b);
      @(negedge clk);
      start = 1'b0;
      if (b == 0) begin
         check("R6", "done", int'(done_r) + int'(done_n), 2);
         check("R6", "busy", int'(busy_r) + int'(busy_n), 0);
         check("R6", "flag", int'(dbz_r) + int'(dbz_n), 2);
         check("R6", "quotient all ones", int'(q_r & q_n), (1 << W) - 1);
         check("R6", "remainder", int'(r_r), a);
         check("R6", "remainder nr", int'(r_n), a);
         @(negedge clk);
         check("R2", "done drops", int'(done_r) + int'(done_n), 0);
         return;
      end
      check("R2", "busy first cycle", int'(busy_r) + int'(busy_n), 2);
      check("R2", "no early done", int'(done_r) + int'(done_n), 0);
      if (ia >= 0) begin
         @(negedge clk);
         start = 1'b1; dividend = W'(ia); divisor = W'(ib);
         @(negedge clk);
         start = 1'b0;
         repeat (W - 2) @(negedge clk);
      end else begin
         repeat (W) @(negedge clk);
      end
      check("R2", "busy last cycle", int'(busy_r) + int'(busy_n), 2);
      @(negedge clk);
      check("R2", "busy falls", int'(busy_r) + int'(busy_n), 0);
      check("R2", "done pulse", int'(done_r) + int'(done_n), 2);
      if (ia >= 0) begin
         check("R7", "quotient after ignored start", int'(q_r), a / b);
         check("R7", "remainder after ignored start", int'(r_n), a % b);
      end
      check_results(a, b);
      hq = q_n; hr = r_r;
      @(negedge clk);
      check("R2", "done one cycle", int'(done_r) + int'(done_n), 0);
      check("R8", "quotient held", int'(q_n), int'(hq));
      check("R8", "remainder held", int'(r_r), int'(hr));
      if (ia >= 0)
         check("R7", "no second run", int'(busy_r) + int'(busy_n), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "busy in reset", int'(busy_r) + int'(busy_n), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy/done/flag", int'(busy_r | done_r | dbz_r | busy_n | done_n | dbz_n), 0);
      check("R1", "outputs zero", int'(q_r | r_r | q_n | r_n), 0);

      // example from the algorithm walk-through: 7 / 2 -> 3 rem 1
      run_one(7, 2, -1, 0);

      // exhaustive sweep over all operand pairs
      for (int a = 0; a < (1 << W); a++)
         for (int b = 0; b < (1 << W); b++)
            run_one(a, b, -1, 0);

      // R7: start during busy is ignored
      run_one(13, 3, 15, 1);
      run_one(5, 7, 2, 0);

      // R6 flag cleared by the next normal completion
      run_one(9, 0, -1, 0);
      run_one(15, 15, -1, 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule